// File: doc/BRIEF.md
# Single-Slot Pipeline Queue

This block is a queue with room for exactly one data word, meant to sit between two pipeline stages. A producer offers a word with a push request and a consumer removes the held word with a pop request. The block keeps one data register and one occupancy bit.

Within a cycle, the consumer reads the held word first, then the pop takes effect, and then the push. The ready-to-accept indication therefore already counts a pop made in the same cycle. A full slot can be drained and refilled in one cycle, so the stream moves at one word per clock with only one register of storage.

The ready indication is the only output that depends on an input in the same cycle: it is a single OR gate on the pop request. The held word and the occupancy flag come straight from registers.

Top module: `pipe_slot_queue`

## Requirements
- R1: After the synchronous active-high reset, the slot is empty: `has_word` is 0 and `can_push` is 1.
- R2: `has_word` shows the occupancy at the start of the cycle. A push accepted in one cycle makes `has_word` 1 from the next cycle on, and not in the same cycle.
- R3: `can_push` is 1 exactly when the slot is empty or `pop_req` is high in that cycle. An empty slot ignores the pop, but `can_push` is still 1.
- R4: `head_data` shows the word stored at the start of the cycle. A word pushed in a cycle appears on `head_data` from the next cycle on.
- R5: When the slot is full and both `push_req` and `pop_req` are high, the old word is consumed and the new word is stored. The slot stays full.
- R6: A pop while the slot is empty and no push is made is ignored. The slot stays empty, and a later push is still accepted normally.
- R7: A push while `can_push` is 0 (full slot, no pop) is ignored. The slot stays full and `head_data` keeps its old word.
- R8: A pop without a push on a full slot empties it in the next cycle.
- R9: If the consumer pops in every cycle and the producer pushes in every cycle, a word is accepted and delivered in every cycle, with no lost or repeated words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Producer offers `push_data` this cycle |
| push_data | input | DATA_W | Word offered by the producer |
| pop_req | input | 1 | Consumer takes the held word this cycle |
| head_data | output | DATA_W | Word held at the start of the cycle |
| has_word | output | 1 | Slot is occupied at the start of the cycle |
| can_push | output | 1 | A push in this cycle will be accepted |

## Verification
The bench builds the block with DATA_W set to 8. Each pushed word is a distinct count value, so a word that is lost, repeated or overwritten shows up as a mismatch in the scoreboard. The scoreboard has only one entry, so the cases that can go wrong sit at the edges of the cycle order. These are a swap on a full slot, a pop on an empty slot, a push that is refused, and a run of back-to-back pushes and pops. The bench drives each of them directly and compares the outputs in the same cycle.

// File: rtl/pipe_slot_pkg.sv
package pipe_slot_pkg;

  typedef enum logic [1:0] {
    SLOT_HOLD  = 2'd0,
    SLOT_FILL  = 2'd1,
    SLOT_DRAIN = 2'd2,
    SLOT_SWAP  = 2'd3
  } slot_op_e;

  // Decode of the effective operations, in order: read, then pop, then push.
  function automatic slot_op_e slot_op(input logic take_push, input logic take_pop);
    slot_op_e op;
    case ({take_push, take_pop})
      2'b10:   op = SLOT_FILL;
      2'b01:   op = SLOT_DRAIN;
      2'b11:   op = SLOT_SWAP;
      default: op = SLOT_HOLD;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/slot_occupancy.sv
module slot_occupancy
  import pipe_slot_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     push_req,
  input  logic     pop_req,
  output logic     occupied,
  output logic     ready,
  output logic     take_push,
  output slot_op_e op
);

  logic occ_q;
  logic take_pop;

  // A pop counts only while the slot holds a word.
  assign take_pop  = pop_req & occ_q;
  // Ready already includes a pop made in this cycle.
  assign ready     = ~occ_q | pop_req;
  assign take_push = push_req & ready;
  assign op        = slot_op(take_push, take_pop);
  assign occupied  = occ_q;

  // The fill wins when set and clear come in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= 1'b0;
    end else begin
      case (op)
        SLOT_FILL, SLOT_SWAP: occ_q <= 1'b1;
        SLOT_DRAIN:           occ_q <= 1'b0;
        default:              occ_q <= occ_q;
      endcase
    end
  end

endmodule

// File: rtl/slot_word_store.sv
module slot_word_store #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] word_q;

  // Plain enabled register with no reset, so it maps onto fabric flops.
  always_ff @(posedge clk) begin
    if (load) begin
      word_q <= din;
    end
  end

  assign dout = word_q;

endmodule

// File: rtl/pipe_slot_queue.sv
module pipe_slot_queue
  import pipe_slot_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head_data,
  output logic              has_word,
  output logic              can_push
);

  logic     take_push;
  slot_op_e op;

  slot_occupancy u_occ (
    .clk       (clk),
    .rst       (rst),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .occupied  (has_word),
    .ready     (can_push),
    .take_push (take_push),
    .op        (op)
  );

  slot_word_store #(.DATA_W(DATA_W)) u_store (
    .clk  (clk),
    .load (take_push),
    .din  (push_data),
    .dout (head_data)
  );

endmodule

// File: rtl/pipe_slot_queue_chk.sv
module pipe_slot_queue_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              push_req,
  input logic [DATA_W-1:0] push_data,
  input logic              pop_req,
  input logic [DATA_W-1:0] head_data,
  input logic              has_word,
  input logic              can_push
);

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (push_req && !has_word) |=> (has_word && head_data == $past(push_data))); // R2

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (rst)
    !has_word |-> can_push); // R3

  AST_SWAP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (has_word && push_req && pop_req) |=> (has_word && head_data == $past(push_data))); // R5

  AST_IDLE_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!has_word && pop_req && !push_req) |=> !has_word); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (has_word && push_req && !pop_req) |=> (has_word && $stable(head_data))); // R7

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (has_word && pop_req && !push_req) |=> !has_word); // R8

endmodule

bind pipe_slot_queue pipe_slot_queue_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .push_req  (push_req),
  .push_data (push_data),
  .pop_req   (pop_req),
  .head_data (head_data),
  .has_word  (has_word),
  .can_push  (can_push)
);

// File: tb/tb_pipe_slot_queue.sv
module tb_pipe_slot_queue;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         push_req = 1'b0;
  logic [W-1:0] push_data = '0;
  logic         pop_req = 1'b0;
  logic [W-1:0] head_data;
  logic         has_word;
  logic         can_push;

  int           n_vec = 0;
  int           n_bad = 0;
  logic [W-1:0] sb[$];
  bit           m_occ = 1'b0;
  int           n_pops = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  pipe_slot_queue #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .push_req(push_req), .push_data(push_data),
    .pop_req(pop_req), .head_data(head_data), .has_word(has_word), .can_push(can_push)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares the outputs with the model, pops the scoreboard on a delivery.
  task automatic monitor(input string req);
    chk(has_word == m_occ, {req, " has_word"}, has_word, m_occ);
    chk(can_push == (!m_occ || pop_req), {req, " can_push"}, can_push, !m_occ || pop_req);
    if (m_occ) chk(head_data == sb[0], {req, " head_data"}, head_data, sb[0]);
    if (m_occ && pop_req) begin
      void'(sb.pop_front());
      n_pops++;
    end
  endtask

  // Driver: applies one cycle and pushes the expected word when the push is accepted.
  task automatic step(input bit e, input logic [W-1:0] d, input bit q, input string req);
    bit take;
    @(negedge clk);
    push_req = e; push_data = d; pop_req = q;
    #2;
    take = e && (!m_occ || q);
    monitor(req);
    if (take) sb.push_back(d);
    if (take) m_occ = 1'b1;
    else if (q && m_occ) m_occ = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    #2;
    chk(has_word == 1'b0, "R1 has_word", has_word, 0);
    chk(can_push == 1'b1, "R1 can_push", can_push, 1);
    // R6: pop on empty is ignored
    step(0, 8'h00, 1, "R6");
    step(0, 8'h00, 0, "R6");
    // R2, R4: fill then observe
    step(1, 8'h11, 0, "R2");
    step(0, 8'h00, 0, "R4");
    // R7: push while full, no pop, ignored
    step(1, 8'hEE, 0, "R7");
    step(0, 8'h00, 0, "R7");
    // R5: swap on full slot
    step(1, 8'h22, 1, "R5");
    step(0, 8'h00, 0, "R5");
    // R8: drain
    step(0, 8'h00, 1, "R8");
    step(0, 8'h00, 0, "R8");
    // R3: ready with pop on empty plus push
    step(1, 8'h33, 1, "R3");
    step(0, 8'h00, 1, "R3");
    // R9: streaming one word per cycle
    n_pops = 0;
    step(1, 8'h40, 0, "R9");
    for (int i = 1; i <= 20; i++) step(1, 8'(8'h40 + i), 1, "R9");
    step(0, 8'h00, 1, "R9");
    step(0, 8'h00, 0, "R9");
    chk(n_pops == 21, "R9 delivered", n_pops, 21);
    chk(sb.size() == 0, "R9 leftover", sb.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule